// File: doc/BRIEF.md
# Control-Transfer Next-PC Resolver

This purely combinational unit sits beside the fetch stage of an RV32I core. It takes the PC of the current instruction, its raw 32-bit word and the two source-register values, and it works out the address to fetch next. It handles the six conditional branches and the two jumps, `jal` and `jalr`. Every other instruction falls through to PC + 4.

Inside the unit there are three separate stages:
- a comparator that evaluates the branch condition;
- a target calculator that decodes the B, J and I immediates and forms each candidate address;
- a selector that picks the PC source, drives the taken flag and builds the link writeback.

The selected PC source is brought out on its own port for debug. Pipeline flush and trapping are left to surrounding logic. That logic reads the taken flag and the misalignment flag that this unit provides.

Top module: `cf_nextpc`

## Requirements
- R1: With an opcode other than 1100011 (branch), 1101111 (jal) or 1100111 (jalr), `next_pc_o` is `pc_i` + 4, `taken_o` is 0, `link_we_o` is 0 and `pc_sel_o` is 0.
- R2: Branch funct3 000 (equal) and 001 (not equal) compare rs1 with rs2. When the condition holds, the result is the branch target. Otherwise the result is `pc_i` + 4.
- R3: Branch funct3 100 (less than) and 101 (greater or equal) compare the operands as two's-complement numbers.
- R4: Branch funct3 110 (less than) and 111 (greater or equal) compare the operands as unsigned numbers.
- R5: Branch funct3 010 and 011 are never taken, whatever the operand values.
- R6: The branch target is `pc_i` + the sign-extended immediate {instr[31], instr[7], instr[30:25], instr[11:8], 0}. This covers both backward offsets and the extremes of the range.
- R7: `jal` always goes to `pc_i` + the sign-extended immediate {instr[31], instr[19:12], instr[20], instr[30:21], 0}. It writes `pc_i` + 4 to rd = instr[11:7].
- R8: `jalr` goes to rs1 + sign-extended instr[31:20], with bit 0 of the sum cleared. It writes `pc_i` + 4 to rd.
- R9: `link_we_o` is 1 only for a jump whose rd is not x0. Branches never link.
- R10: `misalign_o` is 1 exactly when a transfer is taken and bit 1 of the selected target is set.
- R11: `pc_sel_o` encodes the source as 0 for fall-through, 1 for branch, 2 for jal and 3 for jalr. `taken_o` is 1 exactly when `pc_sel_o` is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | PC of the instruction being resolved |
| instr_i | input | 32 | Raw instruction word |
| rs1_i | input | 32 | Value of source register 1 |
| rs2_i | input | 32 | Value of source register 2 |
| next_pc_o | output | 32 | Address to fetch next |
| taken_o | output | 1 | A control transfer is taken |
| link_we_o | output | 1 | Return-address write enable |
| link_rd_o | output | 5 | Return-address destination register |
| link_data_o | output | 32 | Return address, PC + 4 |
| misalign_o | output | 1 | Taken target is not 4-byte aligned |
| pc_sel_o | output | 2 | Selected PC source, for debug |

## Verification
The hardest cases to reach are the few where the immediate scramble and the comparator sign handling both matter. These are:
- branch offsets at the far ends of the range;
- signed and unsigned compares on the same operands that disagree;
- a `jalr` sum with bit 0 set, where clearing that bit still leaves bit 1 set.

The bench builds each instruction word from a chosen offset with its own field packer. It then applies operand pairs that differ only in their sign interpretation, so each path has a known expected address. Odd `jalr` sums and 2-byte branch offsets are used to drive the misalignment flag.

// File: rtl/cf_nextpc_pkg.sv
package cf_nextpc_pkg;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;

  localparam logic [2:0] F3_EQ  = 3'b000;
  localparam logic [2:0] F3_NE  = 3'b001;
  localparam logic [2:0] F3_LT  = 3'b100;
  localparam logic [2:0] F3_GE  = 3'b101;
  localparam logic [2:0] F3_LTU = 3'b110;
  localparam logic [2:0] F3_GEU = 3'b111;

  typedef enum logic [1:0] {
    PCSEL_SEQ  = 2'd0,
    PCSEL_BR   = 2'd1,
    PCSEL_JAL  = 2'd2,
    PCSEL_JALR = 2'd3
  } pcsel_e;
endpackage

// File: rtl/cf_cmp.sv
module cf_cmp
  import cf_nextpc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter bit USE_SUB = 1'b1  // share one subtractor for all relations
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [2:0]      funct3_i,
  output logic            cond_o
);
  localparam int MSB = XLEN - 1;

  logic eq, lt_s, lt_u;

  if (USE_SUB) begin : g_sub
    logic [XLEN:0] diff;
    assign diff = {1'b0, a_i} - {1'b0, b_i};
    assign eq   = (diff[MSB:0] == '0);
    assign lt_u = diff[XLEN];  // borrow
    // differing signs: a is smaller iff a negative
    assign lt_s = (a_i[MSB] ^ b_i[MSB]) ? a_i[MSB] : diff[XLEN];
  end else begin : g_cmp
    assign eq   = (a_i == b_i);
    assign lt_u = (a_i < b_i);
    assign lt_s = ($signed(a_i) < $signed(b_i));
  end

  always_comb begin
    unique case (funct3_i)
      F3_EQ:   cond_o = eq;
      F3_NE:   cond_o = !eq;
      F3_LT:   cond_o = lt_s;
      F3_GE:   cond_o = !lt_s;
      F3_LTU:  cond_o = lt_u;
      F3_GEU:  cond_o = !lt_u;
      default: cond_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cf_tgt.sv
module cf_tgt #(
  parameter int XLEN      = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [31:7]     insn_i,
  input  logic [XLEN-1:0] rs1_i,
  output logic [XLEN-1:0] seq_o,
  output logic [XLEN-1:0] br_tgt_o,
  output logic [XLEN-1:0] jal_tgt_o,
  output logic [XLEN-1:0] jalr_tgt_o
);
  localparam int BW = 13;
  localparam int JW = 21;
  localparam int IW = 12;

  logic [XLEN-1:0] imm_b, imm_j, imm_i, jalr_sum;

  assign imm_b = {{(XLEN-BW){insn_i[31]}}, insn_i[31], insn_i[7],
                  insn_i[30:25], insn_i[11:8], 1'b0};
  assign imm_j = {{(XLEN-JW){insn_i[31]}}, insn_i[31], insn_i[19:12],
                  insn_i[20], insn_i[30:21], 1'b0};
  assign imm_i = {{(XLEN-IW){insn_i[31]}}, insn_i[31:20]};

  assign seq_o      = pc_i + XLEN'(INSN_BYTES);
  assign br_tgt_o   = pc_i + imm_b;
  assign jal_tgt_o  = pc_i + imm_j;
  assign jalr_sum   = rs1_i + imm_i;
  assign jalr_tgt_o = {jalr_sum[XLEN-1:1], 1'b0};
endmodule

// File: rtl/cf_sel.sv
module cf_sel
  import cf_nextpc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [6:0]      opcode_i,
  input  logic [4:0]      rd_i,
  input  logic            cond_i,
  input  logic [XLEN-1:0] seq_i,
  input  logic [XLEN-1:0] br_tgt_i,
  input  logic [XLEN-1:0] jal_tgt_i,
  input  logic [XLEN-1:0] jalr_tgt_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic            taken_o,
  output logic            link_we_o,
  output logic            misalign_o,
  output pcsel_e          sel_o
);
  logic is_jump;

  always_comb begin
    unique case (opcode_i)
      OPC_BRANCH: sel_o = cond_i ? PCSEL_BR : PCSEL_SEQ;
      OPC_JAL:    sel_o = PCSEL_JAL;
      OPC_JALR:   sel_o = PCSEL_JALR;
      default:    sel_o = PCSEL_SEQ;
    endcase
  end

  always_comb begin
    unique case (sel_o)
      PCSEL_BR:   next_pc_o = br_tgt_i;
      PCSEL_JAL:  next_pc_o = jal_tgt_i;
      PCSEL_JALR: next_pc_o = jalr_tgt_i;
      default:    next_pc_o = seq_i;
    endcase
  end

  assign is_jump    = (sel_o == PCSEL_JAL) || (sel_o == PCSEL_JALR);
  assign taken_o    = (sel_o != PCSEL_SEQ);
  assign link_we_o  = is_jump && (rd_i != 5'd0);
  // no compressed ISA: targets must be word aligned
  assign misalign_o = taken_o && next_pc_o[1];
endmodule

// File: rtl/cf_nextpc.sv
module cf_nextpc
  import cf_nextpc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter bit USE_SUB = 1'b1
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic            taken_o,
  output logic            link_we_o,
  output logic [4:0]      link_rd_o,
  output logic [XLEN-1:0] link_data_o,
  output logic            misalign_o,
  output logic [1:0]      pc_sel_o
);
  logic            cond;
  logic [XLEN-1:0] seq, br_tgt, jal_tgt, jalr_tgt;
  pcsel_e          sel;

  cf_cmp #(.XLEN(XLEN), .USE_SUB(USE_SUB)) u_cmp (
    .a_i      (rs1_i),
    .b_i      (rs2_i),
    .funct3_i (instr_i[14:12]),
    .cond_o   (cond)
  );

  cf_tgt #(.XLEN(XLEN)) u_tgt (
    .pc_i       (pc_i),
    .insn_i     (instr_i[31:7]),
    .rs1_i      (rs1_i),
    .seq_o      (seq),
    .br_tgt_o   (br_tgt),
    .jal_tgt_o  (jal_tgt),
    .jalr_tgt_o (jalr_tgt)
  );

  cf_sel #(.XLEN(XLEN)) u_sel (
    .opcode_i   (instr_i[6:0]),
    .rd_i       (instr_i[11:7]),
    .cond_i     (cond),
    .seq_i      (seq),
    .br_tgt_i   (br_tgt),
    .jal_tgt_i  (jal_tgt),
    .jalr_tgt_i (jalr_tgt),
    .next_pc_o  (next_pc_o),
    .taken_o    (taken_o),
    .link_we_o  (link_we_o),
    .misalign_o (misalign_o),
    .sel_o      (sel)
  );

  assign link_rd_o   = instr_i[11:7];
  assign link_data_o = seq;
  assign pc_sel_o    = sel;
endmodule

// File: rtl/cf_nextpc_chk.sv
module cf_nextpc_chk #(
  parameter int XLEN = 32
) (
  input logic [XLEN-1:0] pc_i,
  input logic [31:0]     instr_i,
  input logic [XLEN-1:0] next_pc_o,
  input logic            taken_o,
  input logic            link_we_o,
  input logic [4:0]      link_rd_o,
  input logic [XLEN-1:0] link_data_o,
  input logic            misalign_o,
  input logic [1:0]      pc_sel_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  always_comb begin
    a_r1_fallthrough: assert (taken_o || next_pc_o == pc_i + STEP)
      else $error("not-taken result is not pc+4");
    a_r11_sel_taken: assert (taken_o == (pc_sel_o != 2'd0))
      else $error("taken flag disagrees with pc source");
    a_r9_no_x0_link: assert (!link_we_o || (link_rd_o != 5'd0 && pc_sel_o[1]))
      else $error("link write to x0 or from non-jump");
    a_r7_link_value: assert (!link_we_o || link_data_o == pc_i + STEP)
      else $error("link value is not pc+4");
    a_r8_jalr_even: assert (pc_sel_o != 2'd3 || !next_pc_o[0])
      else $error("jalr target bit 0 set");
    a_r10_misalign: assert (misalign_o == (taken_o && next_pc_o[1]))
      else $error("misalign flag mismatch");
    a_r1_other_opcode: assert (instr_i[6:2] == 5'b11000 || instr_i[6:2] == 5'b11011 ||
                               instr_i[6:2] == 5'b11001 || !taken_o)
      else $error("non-control opcode took a transfer");
  end
endmodule

bind cf_nextpc cf_nextpc_chk #(.XLEN(XLEN)) u_chk (
  .pc_i        (pc_i),
  .instr_i     (instr_i),
  .next_pc_o   (next_pc_o),
  .taken_o     (taken_o),
  .link_we_o   (link_we_o),
  .link_rd_o   (link_rd_o),
  .link_data_o (link_data_o),
  .misalign_o  (misalign_o),
  .pc_sel_o    (pc_sel_o)
);

// File: tb/sim_cf_nextpc.sv
module sim_cf_nextpc;
  timeunit 1ns;
  timeprecision 1ps;

  typedef struct {
    logic [31:0] next_pc;
    logic        taken;
    logic        we;
    logic [4:0]  rd;
    logic [31:0] data;
    logic        mis;
    logic [1:0]  sel;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pc, instr, rs1, rs2;
  logic [31:0] next_pc, link_data;
  logic        taken, link_we, misalign;
  logic [4:0]  link_rd;
  logic [1:0]  pc_sel;

  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 1'b0;
  exp_t sb[$];

  always #2 clk = ~clk;

  cf_nextpc u0 (
    .pc_i(pc), .instr_i(instr), .rs1_i(rs1), .rs2_i(rs2),
    .next_pc_o(next_pc), .taken_o(taken), .link_we_o(link_we),
    .link_rd_o(link_rd), .link_data_o(link_data),
    .misalign_o(misalign), .pc_sel_o(pc_sel)
  );

  // field packers
  function automatic logic [31:0] enc_b(input logic [12:0] o, input logic [2:0] f3);
    return {o[12], o[10:5], 5'd2, 5'd1, f3, o[4:1], o[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] enc_j(input logic [20:0] o, input logic [4:0] rd);
    return {o[20], o[10:1], o[11], o[19:12], rd, 7'b1101111};
  endfunction
  function automatic logic [31:0] enc_i(input logic [11:0] o, input logic [4:0] rd);
    return {o, 5'd1, 3'b000, rd, 7'b1100111};
  endfunction

  task automatic drive(input logic [31:0] p, input logic [31:0] w,
                       input logic [31:0] a, input logic [31:0] b, input exp_t e);
    @(posedge clk);
    pc = p; instr = w; rs1 = a; rs2 = b;
    sb.push_back(e);
  endtask

  task automatic t_seq(input logic [31:0] p, input logic [31:0] w, input string tag);
    exp_t e;
    e.next_pc = p + 4; e.taken = 0; e.we = 0; e.rd = 0; e.data = 0;
    e.mis = 0; e.sel = 2'd0; e.tag = tag;
    drive(p, w, 32'h1234_5678, 32'h1234_5678, e);
  endtask

  task automatic t_br(input logic [31:0] p, input logic [2:0] f3, input int off,
                      input logic [31:0] a, input logic [31:0] b,
                      input bit tk, input string tag);
    exp_t e;
    e.next_pc = tk ? p + 32'(off) : p + 4;
    e.taken = tk; e.we = 0; e.rd = 0; e.data = 0;
    e.mis = tk && e.next_pc[1]; e.sel = tk ? 2'd1 : 2'd0; e.tag = tag;
    drive(p, enc_b(13'(off), f3), a, b, e);
  endtask

  task automatic t_jal(input logic [31:0] p, input int off, input logic [4:0] rd,
                       input string tag);
    exp_t e;
    e.next_pc = p + 32'(off); e.taken = 1; e.we = (rd != 0); e.rd = rd;
    e.data = p + 4; e.mis = e.next_pc[1]; e.sel = 2'd2; e.tag = tag;
    drive(p, enc_j(21'(off), rd), 0, 0, e);
  endtask

  task automatic t_jalr(input logic [31:0] p, input logic [31:0] base, input int off,
                        input logic [31:0] tgt, input logic [4:0] rd, input string tag);
    exp_t e;
    e.next_pc = tgt; e.taken = 1; e.we = (rd != 0); e.rd = rd;
    e.data = p + 4; e.mis = tgt[1]; e.sel = 2'd3; e.tag = tag;
    drive(p, enc_i(12'(off), rd), base, 32'h0, e);
  endtask

  // monitor
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      bit   bad;
      e = sb.pop_front();
      n_chk++;
      bad = (next_pc !== e.next_pc) || (taken !== e.taken) || (link_we !== e.we) ||
            (misalign !== e.mis) || (pc_sel !== e.sel) ||
            (e.we && (link_rd !== e.rd || link_data !== e.data));
      if (bad) begin
        n_err++;
        $display("FAIL %s: got pc=%h tk=%0b we=%0b rd=%0d ld=%h mis=%0b sel=%0d exp pc=%h tk=%0b we=%0b rd=%0d ld=%h mis=%0b sel=%0d",
                 e.tag, next_pc, taken, link_we, link_rd, link_data, misalign, pc_sel,
                 e.next_pc, e.taken, e.we, e.rd, e.data, e.mis, e.sel);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    pc = 0; instr = 32'h0000_0013; rs1 = 0; rs2 = 0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;

    t_seq(32'h0, 32'h0000_0013, "R1 reset nop");
    t_seq(32'h100, 32'h00A0_0093, "R1 addi");
    t_seq(32'h2000, 32'h1234_50B7, "R1 lui");

    t_br(32'h400, 3'b000, 16, 32'd7, 32'd7, 1, "R2 beq taken");
    t_br(32'h400, 3'b000, 16, 32'd7, 32'd8, 0, "R2 beq not taken");
    t_br(32'h400, 3'b001, 32, 32'd1, 32'd2, 1, "R2 bne taken");
    t_br(32'h400, 3'b001, 32, 32'd5, 32'd5, 0, "R2 bne not taken");

    t_br(32'h800, 3'b100, 12, 32'hFFFF_FFFF, 32'd1, 1, "R3 blt neg<pos");
    t_br(32'h800, 3'b100, 12, 32'd5, 32'd3, 0, "R3 blt not taken");
    t_br(32'h800, 3'b101, 12, 32'hFFFF_FFFF, 32'd1, 0, "R3 bge not taken");
    t_br(32'h800, 3'b101, 12, 32'h8000_0000, 32'h8000_0000, 1, "R3 bge equal");

    t_br(32'h800, 3'b110, 20, 32'hFFFF_FFFF, 32'd1, 0, "R4 bltu not taken");
    t_br(32'h800, 3'b110, 20, 32'd1, 32'd2, 1, "R4 bltu taken");
    t_br(32'h800, 3'b111, 20, 32'hFFFF_FFFF, 32'd1, 1, "R4 bgeu taken");
    t_br(32'h800, 3'b111, 20, 32'd0, 32'd1, 0, "R4 bgeu not taken");

    t_br(32'h900, 3'b010, 8, 32'd3, 32'd3, 0, "R5 funct3 010");
    t_br(32'h900, 3'b011, 8, 32'd0, 32'd9, 0, "R5 funct3 011");

    t_br(32'h200, 3'b000, -8, 32'd0, 32'd0, 1, "R6 backward");
    t_br(32'h1_0000, 3'b000, 4094, 32'd0, 32'd0, 1, "R6 max offset");
    t_br(32'h1_0000, 3'b000, -4096, 32'd0, 32'd0, 1, "R6 min offset");

    t_jal(32'h3000, 2048, 5'd1, "R7 jal");
    t_jal(32'h10_0000, 1048572, 5'd5, "R7 jal max");
    t_jal(32'h20_0000, -1048576, 5'd31, "R7 jal min");

    t_jalr(32'h500, 32'h3001, 3, 32'h3004, 5'd1, "R8 jalr clear bit0");
    t_jalr(32'h500, 32'h1000, -4, 32'h0FFC, 5'd2, "R8 jalr negative");

    t_jal(32'h600, 64, 5'd0, "R9 jal rd x0");
    t_jalr(32'h600, 32'h4000, 0, 32'h4000, 5'd0, "R9 jalr rd x0");

    t_br(32'h700, 3'b000, 6, 32'd0, 32'd0, 1, "R10 branch misalign");
    t_br(32'h700, 3'b001, 6, 32'd0, 32'd0, 0, "R10 not taken no misalign");
    t_jal(32'h700, 2, 5'd1, "R10 jal misalign");
    t_jalr(32'h700, 32'h2000, -1, 32'h1FFE, 5'd1, "R10 jalr misalign");
    t_jalr(32'h700, 32'h2001, 1, 32'h2002, 5'd3, "R11 jalr source");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule